// File: doc/BRIEF.md
# Supervisor Output Channel with Dependency Mask

This block drives one programmable output of a power supervisor. It watches a set of fault sources: six undervoltage monitors, a watchdog fault, four general-purpose inputs, the asserted states of seven sibling output channels, and a manual reset pin. A per-channel mask selects which of these sources the output follows. If any selected source reports a fault, the output asserts on the next clock edge. It releases only after every selected source has stayed clear for a programmable release delay. A polarity bit decides whether the asserted state appears on the pin as high or as low.

Configuration arrives through a plain write port with a 2-bit address and an 8-bit data word. A prescaler turns the system clock into a base tick of `TICK_DIV` cycles, which stands for 25 µs. A 3-bit code then picks the release delay as a multiple of that tick. Sibling states are registered before use, so several channels can depend on each other without forming a combinational loop.

The control is a four-state machine:
- `ST_HOLD`: the mask is empty, and the output is forced asserted.
- `ST_ASSERT`: a selected fault is present.
- `ST_WAIT`: all selected sources are clear and the release delay is running.
- `ST_IDLE`: the output is deasserted.

The transitions are:
- From any state, an empty mask leads to `ST_HOLD`.
- From `ST_HOLD`, `ST_WAIT` or `ST_IDLE`, a fault leads to `ST_ASSERT`.
- From `ST_ASSERT` or `ST_HOLD`, no fault leads to `ST_WAIT`.
- From `ST_WAIT`, expiry of the delay leads to `ST_IDLE`.

The output is asserted in every state except `ST_IDLE`.

Top module: `sup_out_chan`

## Requirements
- R1: After reset, all masks are zero, the delay code is 0 and polarity is active-low, so the output is asserted (`out_asserted`=1, `out_pin`=0).
- R2: When no undervoltage, watchdog, general-purpose or sibling source is selected, the output stays asserted whatever the inputs are. This includes a mask that selects only manual reset (address 1 bit 4). The forced assertion shows one cycle after the write that empties the mask.
- R3: A selected undervoltage input that is low (`uv_ok[i]`=0; address 0 bits 5:0 select inputs 0 to 5) asserts the output on the next clock edge.
- R4: Sources whose mask bit is 0 have no effect on the output.
- R5: Each of the following asserts the output on the next edge when it is selected:
  - watchdog fault high (address 0 bit 6);
  - general-purpose input high (address 1 bits 3:0);
  - `mr_n` low (address 1 bit 4).
- R6: A selected sibling that is high (address 2 bits 6:0) asserts the output two edges after it is applied, because siblings pass through one register stage.
- R7: Release delay:
  - Once all selected sources are clear, the output deasserts exactly 1 + L·`TICK_DIV` cycles later.
  - L comes from the code in address 3 bits 2:0: 0→1, 1→60, 2→250, 3→1000, 4→2000, 5→8000, 6→16000, 7→64000 ticks.
  - The output never deasserts while a selected fault is present.
- R8: A fault during the release delay re-asserts the output and restarts the delay in full from the next clear cycle.
- R9: Address 3 bit 3 sets polarity: 1 drives `out_pin` equal to `out_asserted`, and 0 drives it inverted.
- R10: Reserved data bits (address 0 bit 7, address 1 bits 7:5, address 2 bit 7, address 3 bits 7:4) are discarded and select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| uv_ok | input | N_UV | Undervoltage monitor flags, 0 = below threshold |
| wdog_fault | input | 1 | Watchdog fault, 1 = fault |
| gpi | input | N_GPI | General-purpose inputs, 1 = active |
| sib_asserted | input | N_SIB | Asserted states of sibling channels |
| mr_n | input | 1 | Manual reset pin, low = active |
| out_asserted | output | 1 | Logical asserted state of this channel |
| out_pin | output | 1 | Output pin after polarity |

## Verification
Fault-driven results are due at these edges:
- A direct-source fault shows at the first edge after it is applied.
- A sibling fault shows at the second edge.
- A configuration write takes effect one edge after the write is registered.
- A release shows 1 + L·`TICK_DIV` edges after the sources clear.

Each expected result goes into the scoreboard tagged with the exact monitor cycle on which it is due. The monitor samples 1 ns after each rising edge and compares only on that cycle, so a result that arrives one cycle early or late is reported. Checks are placed on both sides of each boundary: the cycle before a release must still read asserted, and the cycle before a sibling fault lands must still read deasserted.

// File: rtl/sup_out_pkg.sv
package sup_out_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_WAIT   = 2'd2,
        ST_IDLE   = 2'd3
    } chan_state_t;

    localparam int CFG_AW  = 2;
    localparam int CFG_DW  = 8;
    localparam int CODE_W  = 3;
    localparam int TICK_CW = 16;

    localparam logic [CFG_AW-1:0] A_UVWD = 2'd0;
    localparam logic [CFG_AW-1:0] A_GPMR = 2'd1;
    localparam logic [CFG_AW-1:0] A_SIB  = 2'd2;
    localparam logic [CFG_AW-1:0] A_TIME = 2'd3;

    // Release delay length in base ticks for each code.
    function automatic logic [TICK_CW-1:0] code_ticks(input logic [CODE_W-1:0] code);
        logic [TICK_CW-1:0] t;
        unique case (code)
            3'd0: t = 16'd1;
            3'd1: t = 16'd60;
            3'd2: t = 16'd250;
            3'd3: t = 16'd1000;
            3'd4: t = 16'd2000;
            3'd5: t = 16'd8000;
            3'd6: t = 16'd16000;
            default: t = 16'd64000;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sup_cfg_regs.sv
module sup_cfg_regs
    import sup_out_pkg::*;
#(
    parameter int N_UV  = 6,
    parameter int N_GPI = 4,
    parameter int N_SIB = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CFG_AW-1:0]   addr,
    input  logic [CFG_DW-1:0]   wdata,
    output logic [N_UV-1:0]     uv_sel,
    output logic                wd_sel,
    output logic [N_GPI-1:0]    gpi_sel,
    output logic                mr_sel,
    output logic [N_SIB-1:0]    sib_sel,
    output logic [CODE_W-1:0]   code,
    output logic                pol_high
);

    localparam int WD_BIT  = N_UV;
    localparam int MR_BIT  = N_GPI;
    localparam int POL_BIT = CODE_W;

    // Reserved bits are never stored; this sink only keeps lint quiet.
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_sel   <= '0;
            wd_sel   <= 1'b0;
            gpi_sel  <= '0;
            mr_sel   <= 1'b0;
            sib_sel  <= '0;
            code     <= '0;
            pol_high <= 1'b0;
        end else if (we) begin
            unique case (addr)
                A_UVWD: begin
                    uv_sel <= wdata[N_UV-1:0];
                    wd_sel <= wdata[WD_BIT];
                end
                A_GPMR: begin
                    gpi_sel <= wdata[N_GPI-1:0];
                    mr_sel  <= wdata[MR_BIT];
                end
                A_SIB: begin
                    sib_sel <= wdata[N_SIB-1:0];
                end
                A_TIME: begin
                    code     <= wdata[CODE_W-1:0];
                    pol_high <= wdata[POL_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sup_fault_merge.sv
module sup_fault_merge #(
    parameter int N_UV  = 6,
    parameter int N_GPI = 4,
    parameter int N_SIB = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_UV-1:0]  uv_sel,
    input  logic             wd_sel,
    input  logic [N_GPI-1:0] gpi_sel,
    input  logic             mr_sel,
    input  logic [N_SIB-1:0] sib_sel,
    input  logic [N_UV-1:0]  uv_ok,
    input  logic             wdog_fault,
    input  logic [N_GPI-1:0] gpi,
    input  logic [N_SIB-1:0] sib_asserted,
    input  logic             mr_n,
    output logic             fault,
    output logic             mask_any
);

    logic [N_SIB-1:0] sib_q;
    logic [N_UV-1:0]  uv_hit;
    logic [N_GPI-1:0] gpi_hit;
    logic [N_SIB-1:0] sib_hit;

    // Registered sibling copies break loops between mutually dependent channels.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sib_q <= '0;
        else        sib_q <= sib_asserted;
    end

    for (genvar i = 0; i < N_UV; i++) begin : g_uv
        assign uv_hit[i] = uv_sel[i] & ~uv_ok[i];
    end
    for (genvar i = 0; i < N_GPI; i++) begin : g_gpi
        assign gpi_hit[i] = gpi_sel[i] & gpi[i];
    end
    for (genvar i = 0; i < N_SIB; i++) begin : g_sib
        assign sib_hit[i] = sib_sel[i] & sib_q[i];
    end

    // The manual reset bit alone does not count as a dependency.
    assign mask_any = (|uv_sel) | wd_sel | (|gpi_sel) | (|sib_sel);

    assign fault = (|uv_hit) | (wd_sel & wdog_fault) | (|gpi_hit)
                 | (|sib_hit) | (mr_sel & ~mr_n);

endmodule

// File: rtl/sup_release_timer.sv
module sup_release_timer
    import sup_out_pkg::*;
#(
    parameter int TICK_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);

    logic                base_tick;
    logic [TICK_CW-1:0]  tick_cnt;
    logic [TICK_CW-1:0]  last_tick;

    assign last_tick = code_ticks(code) - 16'd1;

    if (TICK_DIV > 1) begin : g_presc
        localparam int PW = $clog2(TICK_DIV);
        localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);
        logic [PW-1:0] presc;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                presc <= '0;
            else if (!run)             presc <= '0;
            else if (presc == PRESC_LAST) presc <= '0;
            else                       presc <= presc + 1'b1;
        end
        assign base_tick = run && (presc == PRESC_LAST);
    end else begin : g_nopresc
        assign base_tick = run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tick_cnt <= '0;
        else if (!run)      tick_cnt <= '0;
        else if (base_tick) tick_cnt <= tick_cnt + 1'b1;
    end

    assign expire = base_tick && (tick_cnt == last_tick);

endmodule

// File: rtl/sup_out_chan.sv
module sup_out_chan
    import sup_out_pkg::*;
#(
    parameter int N_UV     = 6,
    parameter int N_GPI    = 4,
    parameter int N_SIB    = 7,
    parameter int TICK_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [N_UV-1:0]   uv_ok,
    input  logic              wdog_fault,
    input  logic [N_GPI-1:0]  gpi,
    input  logic [N_SIB-1:0]  sib_asserted,
    input  logic              mr_n,
    output logic              out_asserted,
    output logic              out_pin
);

    logic [N_UV-1:0]   uv_sel;
    logic              wd_sel;
    logic [N_GPI-1:0]  gpi_sel;
    logic              mr_sel;
    logic [N_SIB-1:0]  sib_sel;
    logic [CODE_W-1:0] cfg_code;
    logic              cfg_pol;
    logic              fault_any;
    logic              mask_any;
    logic              rel_expire;
    chan_state_t       state, state_nx;

    sup_cfg_regs #(.N_UV(N_UV), .N_GPI(N_GPI), .N_SIB(N_SIB)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .uv_sel   (uv_sel),
        .wd_sel   (wd_sel),
        .gpi_sel  (gpi_sel),
        .mr_sel   (mr_sel),
        .sib_sel  (sib_sel),
        .code     (cfg_code),
        .pol_high (cfg_pol)
    );

    sup_fault_merge #(.N_UV(N_UV), .N_GPI(N_GPI), .N_SIB(N_SIB)) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_sel       (uv_sel),
        .wd_sel       (wd_sel),
        .gpi_sel      (gpi_sel),
        .mr_sel       (mr_sel),
        .sib_sel      (sib_sel),
        .uv_ok        (uv_ok),
        .wdog_fault   (wdog_fault),
        .gpi          (gpi),
        .sib_asserted (sib_asserted),
        .mr_n         (mr_n),
        .fault        (fault_any),
        .mask_any     (mask_any)
    );

    sup_release_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .code   (cfg_code),
        .expire (rel_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (!mask_any) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:   state_nx = fault_any ? ST_ASSERT : ST_WAIT;
                ST_ASSERT: state_nx = fault_any ? ST_ASSERT : ST_WAIT;
                ST_WAIT: begin
                    if (fault_any)       state_nx = ST_ASSERT;
                    else if (rel_expire) state_nx = ST_IDLE;
                    else                 state_nx = ST_WAIT;
                end
                ST_IDLE:   state_nx = fault_any ? ST_ASSERT : ST_IDLE;
                default:   state_nx = ST_HOLD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_asserted = (state != ST_IDLE);
        out_pin      = cfg_pol ? out_asserted : ~out_asserted;
    end

endmodule

// File: rtl/sup_out_chan_chk.sv
module sup_out_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic mask_any,
    input logic asserted,
    input logic pin,
    input logic pol,
    input logic expire
);

    // R3
    fault_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> asserted);

    // R2
    empty_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_any |=> asserted);

    // R7
    release_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asserted) |-> $past(expire));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asserted && !fault && mask_any) |=> !asserted);

    // R9
    pin_tracks_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pin) && $stable(pol)) |-> !$stable(asserted));

endmodule

bind sup_out_chan sup_out_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault    (fault_any),
    .mask_any (mask_any),
    .asserted (out_asserted),
    .pin      (out_pin),
    .pol      (cfg_pol),
    .expire   (rel_expire)
);

// File: tb/test_sup_out_chan.sv
module test_sup_out_chan;

    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] uv_ok = '1;
    logic       wdog_fault = 1'b0;
    logic [3:0] gpi = '0;
    logic [6:0] sib_asserted = '0;
    logic       mr_n = 1'b1;
    logic       out_asserted, out_pin;

    always #5 clk = ~clk;

    sup_out_chan #(.TICK_DIV(DIV)) i_sup_out_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .uv_ok(uv_ok), .wdog_fault(wdog_fault),
        .gpi(gpi), .sib_asserted(sib_asserted), .mr_n(mr_n),
        .out_asserted(out_asserted), .out_pin(out_pin)
    );

    typedef struct {
        int    due;
        logic  a;
        logic  pin;
        string req;
    } exp_t;

    exp_t  sbq[$];
    int    mcyc = 0;
    int    checks = 0;
    int    errors = 0;
    logic  pol_m = 1'b0;
    bit    done = 1'b0;

    task automatic expect_in(input int d, input logic a, input string req);
        exp_t e;
        e.due = mcyc + d;
        e.a   = a;
        e.pin = pol_m ? a : ~a;
        e.req = req;
        sbq.push_back(e);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Monitor: sample 1 ns after each rising edge and retire due items.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            mcyc++;
            while (sbq.size() > 0 && sbq[0].due <= mcyc) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (e.due != mcyc || out_asserted !== e.a || out_pin !== e.pin) begin
                    errors++;
                    $display("FAIL %s: cycle %0d asserted=%b pin=%b, expected asserted=%b pin=%b (due %0d)",
                             e.req, mcyc, out_asserted, out_pin, e.a, e.pin, e.due);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        expect_in(1, 1'b1, "R1");
        drain();
        rst_n = 1'b1;
        expect_in(5, 1'b1, "R1");
        drain();

        // R10 reserved bit only: mask stays empty
        wr(2'd0, 8'h80);
        expect_in(1, 1'b1, "R10");
        expect_in(20, 1'b1, "R10");
        drain();

        // R2 manual reset alone counts as empty
        wr(2'd1, 8'h10);
        expect_in(1, 1'b1, "R2");
        expect_in(20, 1'b1, "R2");
        drain();

        // R7 release from hold with code 0
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h01);
        expect_in(2, 1'b1, "R7");
        expect_in(3, 1'b0, "R7");
        drain();

        // R3 selected undervoltage
        uv_ok[0] = 1'b0;
        expect_in(1, 1'b1, "R3");
        expect_in(6, 1'b1, "R7");
        drain();
        uv_ok = '1;
        expect_in(2, 1'b1, "R7");
        expect_in(3, 1'b0, "R7");
        drain();

        // R4 unselected sources ignored
        uv_ok[3] = 1'b0; gpi[1] = 1'b1; sib_asserted[0] = 1'b1; wdog_fault = 1'b1;
        expect_in(1, 1'b0, "R4");
        expect_in(10, 1'b0, "R4");
        drain();
        uv_ok = '1; gpi = '0; sib_asserted = '0; wdog_fault = 1'b0;

        // R5 watchdog
        wr(2'd0, 8'h41);
        wdog_fault = 1'b1;
        expect_in(1, 1'b1, "R5");
        drain();
        wdog_fault = 1'b0;
        expect_in(3, 1'b0, "R5");
        drain();

        // R5 general-purpose input
        wr(2'd1, 8'h12);
        gpi[1] = 1'b1;
        expect_in(1, 1'b1, "R5");
        drain();
        gpi = '0;
        expect_in(3, 1'b0, "R5");
        drain();

        // R5 manual reset with other dependency present
        mr_n = 1'b0;
        expect_in(1, 1'b1, "R5");
        drain();
        mr_n = 1'b1;
        expect_in(3, 1'b0, "R5");
        drain();

        // R6 sibling through register stage
        wr(2'd2, 8'h04);
        sib_asserted[2] = 1'b1;
        expect_in(1, 1'b0, "R6");
        expect_in(2, 1'b1, "R6");
        drain();
        sib_asserted = '0;
        expect_in(3, 1'b1, "R6");
        expect_in(4, 1'b0, "R6");
        drain();

        // R7 code 1: 60 ticks
        wr(2'd3, 8'h01);
        uv_ok[0] = 1'b0;
        expect_in(1, 1'b1, "R7");
        drain();
        uv_ok = '1;
        expect_in(60 * DIV, 1'b1, "R7");
        expect_in(60 * DIV + 1, 1'b0, "R7");
        drain();

        // R8 restart of delay
        uv_ok[0] = 1'b0;
        expect_in(1, 1'b1, "R8");
        drain();
        uv_ok = '1;
        repeat (50) @(negedge clk);
        uv_ok[0] = 1'b0;
        @(negedge clk);
        uv_ok = '1;
        expect_in(60 * DIV, 1'b1, "R8");
        expect_in(60 * DIV + 1, 1'b0, "R8");
        drain();

        // R9 active-high polarity
        wr(2'd3, 8'h08);
        pol_m = 1'b1;
        expect_in(1, 1'b0, "R9");
        drain();
        uv_ok[0] = 1'b0;
        expect_in(1, 1'b1, "R9");
        drain();
        uv_ok = '1;
        expect_in(3, 1'b0, "R9");
        drain();

        // R2 emptying the mask forces assertion
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        expect_in(1, 1'b1, "R2");
        expect_in(30, 1'b1, "R2");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule